// File: doc/BRIEF.md
# Bank Scrub Scheduler

This block keeps the contents of one memory bank alive in an array whose cells hold data only for a short and uncertain time. It walks the pages of the bank in order, from page zero to the last. For each page it reads the data, hands the word to an external error-correction unit, and writes the repaired word back only when a correction was made. A page with an error that cannot be corrected is reported on a one-cycle flag together with its page number, and the sweep goes on.

A pass begins when an idle-time interval counter reaches a programmable limit, or at once on a start pulse. A pass holds the bank through an arbitration handshake. Between two pages, a waiting host access gets the bank for exactly one transfer. The block gives up the bank, grants the host, waits for its completion and then asks for the bank again. At the last page the bank is released and the page index returns to zero. Write data leave on two enable vectors, one that drives ones and one that drives zeros.

Top module: `scrub_sched`

## Requirements
- R1: During and after a synchronous reset, `busy_o`, `bank_req_o`, `io_gnt_o`, `cmd_rd_o`, `cmd_wr_o` and `ue_o` are 0, and `cmd_page_o` is 0.
- R2: While idle, an internal counter starts at 0 and increases by one each cycle. A pass starts (busy_o rises on the next edge) in the cycle where the counter equals `interval_i` or where `kick_i` is 1. A `kick_i` pulse that arrives while a pass is running has no effect on the pass or on the page order.
- R3: A pass first raises `bank_req_o`. No read or write command is issued until `bank_gnt_i` has been seen high, and every command is issued with `bank_req_o` high.
- R4: A page scrub holds `cmd_rd_o` until `cmd_done_i`, then holds `ecc_req_o` with the read word on `ecc_raw_o` until `ecc_ack_i`. A write is issued only if the ECC result has `ecc_fixed_i` = 1 and `ecc_fatal_i` = 0.
- R5: During a write, `wr1_en_o` carries the corrected word and `wr0_en_o` carries its bitwise inverse. Both vectors are zero at all other times, and no bit is high in both.
- R6: When `ecc_fatal_i` = 1 at `ecc_ack_i`, `ue_o` is high for one cycle with the page on `ue_page_o`. No write follows, and the next page is scrubbed.
- R7: After a page that is not the last, if `io_pend_i` is 1, the block drops `bank_req_o` and raises `io_gnt_o` until `io_done_i`. It then requests the bank again and continues with the following page.
- R8: After a page that is not the last, with `io_pend_i` = 0, the block keeps `bank_req_o` high and reads the following page directly.
- R9: After the last page (PAGES-1), the block drops `bank_req_o` and `busy_o`, and `cmd_page_o` returns to 0, even if `io_pend_i` is 1.
- R10: A release serves one transfer only: `io_gnt_o` falls on the edge after `io_done_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| interval_i | input | INTV_W | Idle cycles before a pass starts |
| kick_i | input | 1 | Immediate pass start while idle |
| bank_req_o | output | 1 | Bank ownership request |
| bank_gnt_i | input | 1 | Bank ownership granted |
| io_pend_i | input | 1 | Host access waiting for this bank |
| io_gnt_o | output | 1 | Bank lent to the host for one transfer |
| io_done_i | input | 1 | Host transfer finished |
| cmd_rd_o | output | 1 | Page read command |
| cmd_wr_o | output | 1 | Page write command |
| cmd_page_o | output | PAGE_W | Current page index |
| cmd_done_i | input | 1 | Read or write command complete |
| rd_data_i | input | DATA_W | Read word, valid with cmd_done_i |
| wr0_en_o | output | DATA_W | Per-bit drive-zero enables |
| wr1_en_o | output | DATA_W | Per-bit drive-one enables |
| ecc_req_o | output | 1 | ECC check request |
| ecc_raw_o | output | DATA_W | Word under check |
| ecc_ack_i | input | 1 | ECC result valid |
| ecc_fixed_i | input | 1 | A correctable error was repaired |
| ecc_fatal_i | input | 1 | Uncorrectable error |
| ecc_data_i | input | DATA_W | Corrected word |
| ue_o | output | 1 | Uncorrectable error pulse |
| ue_page_o | output | PAGE_W | Page of the last uncorrectable error |
| busy_o | output | 1 | Pass in progress |

## Verification
The properties assume that the handshake partners behave. `io_done_i` comes only while the host holds a grant. The ECC unit never flags fixed and fatal for the same word. Completion and acknowledge strobes come only while the matching request is held. The bench's responders form every strobe from the design's current request outputs, so none of these can be violated. Grant, command and host latencies vary over the run, and the pending-access mask changes from pass to pass. This covers both branches after a page and the last-page case with an access still pending.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ACQ   = 3'd1,
    ST_READ  = 3'd2,
    ST_CHECK = 3'd3,
    ST_WRITE = 3'd4,
    ST_NEXT  = 3'd5,
    ST_LEND  = 3'd6
  } scrub_st_e;
endpackage

// File: rtl/scrub_timer.sv
module scrub_timer #(
  parameter int INTV_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              kick,
  input  logic [INTV_W-1:0] limit,
  output logic              fire
);
  logic [INTV_W-1:0] cnt_q;

  always_comb fire = arm && (kick || (cnt_q == limit));

  always_ff @(posedge clk) begin
    if (rst || !arm || fire) cnt_q <= '0;
    else                     cnt_q <= cnt_q + INTV_W'(1);
  end
endmodule

// File: rtl/scrub_page_ctr.sv
module scrub_page_ctr #(
  parameter int PAGES  = 64,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [PAGE_W-1:0] page,
  output logic              last
);
  localparam logic [PAGE_W-1:0] LAST_PG = PAGE_W'(PAGES - 1);

  logic [PAGE_W-1:0] page_q;

  always_comb begin
    page = page_q;
    last = (page_q == LAST_PG);
  end

  always_ff @(posedge clk) begin
    if (rst)       page_q <= '0;
    else if (step) page_q <= last ? '0 : page_q + PAGE_W'(1);
  end
endmodule

// File: rtl/scrub_data.sv
module scrub_data #(
  parameter int DATA_W = 32,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_raw,
  input  logic [DATA_W-1:0] raw_in,
  input  logic              cap_fix,
  input  logic [DATA_W-1:0] fix_in,
  input  logic              ue_set,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              write_on,
  output logic [DATA_W-1:0] raw_out,
  output logic [DATA_W-1:0] wr0_en,
  output logic [DATA_W-1:0] wr1_en,
  output logic              ue,
  output logic [PAGE_W-1:0] ue_page
);
  logic [DATA_W-1:0] raw_q, fix_q;
  logic              ue_q;
  logic [PAGE_W-1:0] ue_page_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q     <= '0;
      fix_q     <= '0;
      ue_q      <= 1'b0;
      ue_page_q <= '0;
    end else begin
      if (cap_raw) raw_q <= raw_in;
      if (cap_fix) fix_q <= fix_in;
      ue_q <= ue_set;
      if (ue_set) ue_page_q <= page_in;
    end
  end

  always_comb begin
    raw_out = raw_q;
    wr1_en  = write_on ? fix_q  : '0;
    wr0_en  = write_on ? ~fix_q : '0;
    ue      = ue_q;
    ue_page = ue_page_q;
  end
endmodule

// File: rtl/scrub_sched.sv
module scrub_sched
  import scrub_pkg::*;
#(
  parameter int PAGES  = 64,
  parameter int DATA_W = 32,
  parameter int INTV_W = 16,
  localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INTV_W-1:0] interval_i,
  input  logic              kick_i,
  output logic              bank_req_o,
  input  logic              bank_gnt_i,
  input  logic              io_pend_i,
  output logic              io_gnt_o,
  input  logic              io_done_i,
  output logic              cmd_rd_o,
  output logic              cmd_wr_o,
  output logic [PAGE_W-1:0] cmd_page_o,
  input  logic              cmd_done_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] wr0_en_o,
  output logic [DATA_W-1:0] wr1_en_o,
  output logic              ecc_req_o,
  output logic [DATA_W-1:0] ecc_raw_o,
  input  logic              ecc_ack_i,
  input  logic              ecc_fixed_i,
  input  logic              ecc_fatal_i,
  input  logic [DATA_W-1:0] ecc_data_i,
  output logic              ue_o,
  output logic [PAGE_W-1:0] ue_page_o,
  output logic              busy_o
);
  scrub_st_e st_q, st_d;

  logic              fire, last, step;
  logic              cap_raw, cap_fix, ue_set;
  logic [PAGE_W-1:0] page;

  scrub_timer #(.INTV_W(INTV_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .arm   (st_q == ST_IDLE),
    .kick  (kick_i),
    .limit (interval_i),
    .fire  (fire)
  );

  scrub_page_ctr #(.PAGES(PAGES), .PAGE_W(PAGE_W)) u_page (
    .clk  (clk),
    .rst  (rst),
    .step (step),
    .page (page),
    .last (last)
  );

  scrub_data #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_data (
    .clk      (clk),
    .rst      (rst),
    .cap_raw  (cap_raw),
    .raw_in   (rd_data_i),
    .cap_fix  (cap_fix),
    .fix_in   (ecc_data_i),
    .ue_set   (ue_set),
    .page_in  (page),
    .write_on (st_q == ST_WRITE),
    .raw_out  (ecc_raw_o),
    .wr0_en   (wr0_en_o),
    .wr1_en   (wr1_en_o),
    .ue       (ue_o),
    .ue_page  (ue_page_o)
  );

  always_comb begin
    st_d    = st_q;
    step    = 1'b0;
    cap_raw = 1'b0;
    cap_fix = 1'b0;
    ue_set  = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (fire) st_d = ST_ACQ;
      ST_ACQ:   if (bank_gnt_i) st_d = ST_READ;
      ST_READ:  if (cmd_done_i) begin
                  cap_raw = 1'b1;
                  st_d    = ST_CHECK;
                end
      ST_CHECK: if (ecc_ack_i) begin
                  if (ecc_fatal_i) begin
                    ue_set = 1'b1;
                    st_d   = ST_NEXT;
                  end else if (ecc_fixed_i) begin
                    cap_fix = 1'b1;
                    st_d    = ST_WRITE;
                  end else begin
                    st_d = ST_NEXT;
                  end
                end
      ST_WRITE: if (cmd_done_i) st_d = ST_NEXT;
      ST_NEXT: begin
        step = 1'b1;
        if (last)           st_d = ST_IDLE;
        else if (io_pend_i) st_d = ST_LEND;
        else                st_d = ST_READ;
      end
      ST_LEND:  if (io_done_i) st_d = ST_ACQ;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  always_comb begin
    busy_o     = (st_q != ST_IDLE);
    bank_req_o = busy_o && (st_q != ST_LEND);
    io_gnt_o   = (st_q == ST_LEND);
    cmd_rd_o   = (st_q == ST_READ);
    cmd_wr_o   = (st_q == ST_WRITE);
    ecc_req_o  = (st_q == ST_CHECK);
    cmd_page_o = page;
  end
endmodule

// File: rtl/scrub_sched_chk.sv
module scrub_sched_chk #(
  parameter int DATA_W = 32,
  parameter int PAGE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              bank_req_o,
  input logic              io_pend_i,
  input logic              io_gnt_o,
  input logic              io_done_i,
  input logic              cmd_rd_o,
  input logic              cmd_wr_o,
  input logic [PAGE_W-1:0] cmd_page_o,
  input logic [DATA_W-1:0] wr0_en_o,
  input logic [DATA_W-1:0] wr1_en_o,
  input logic              ecc_ack_i,
  input logic              ecc_fixed_i,
  input logic              ecc_fatal_i,
  input logic              ue_o,
  input logic              busy_o
);
  // R5
  wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (wr0_en_o & wr1_en_o) == '0);

  // R3
  cmd_owns_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_rd_o || cmd_wr_o) |-> bank_req_o);

  // R7
  lend_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    io_gnt_o |-> !bank_req_o);

  // R10
  one_transfer_chk: assert property (@(posedge clk) disable iff (rst)
    (io_gnt_o && io_done_i) |=> !io_gnt_o);

  // R8
  lend_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(io_gnt_o) |-> $past(io_pend_i));

  // R4
  write_after_fix_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_wr_o) |-> $past(ecc_ack_i && ecc_fixed_i && !ecc_fatal_i));

  // R6
  ue_single_chk: assert property (@(posedge clk) disable iff (rst)
    ue_o |=> !ue_o);

  // R9
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (cmd_page_o == '0));
endmodule

bind scrub_sched scrub_sched_chk #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bank_req_o  (bank_req_o),
  .io_pend_i   (io_pend_i),
  .io_gnt_o    (io_gnt_o),
  .io_done_i   (io_done_i),
  .cmd_rd_o    (cmd_rd_o),
  .cmd_wr_o    (cmd_wr_o),
  .cmd_page_o  (cmd_page_o),
  .wr0_en_o    (wr0_en_o),
  .wr1_en_o    (wr1_en_o),
  .ecc_ack_i   (ecc_ack_i),
  .ecc_fixed_i (ecc_fixed_i),
  .ecc_fatal_i (ecc_fatal_i),
  .ue_o        (ue_o),
  .busy_o      (busy_o)
);

// File: tb/test_scrub_sched.sv
`timescale 1ns/1ps
module test_scrub_sched;
  localparam int PAGES  = 6;
  localparam int DATA_W = 16;
  localparam int INTV_W = 8;
  localparam int PAGE_W = $clog2(PAGES);

  logic              clk = 1'b0;
  logic              rst;
  logic [INTV_W-1:0] interval_i;
  logic              kick_i;
  logic              bank_req_o, bank_gnt_i, io_pend_i, io_gnt_o, io_done_i;
  logic              cmd_rd_o, cmd_wr_o, cmd_done_i;
  logic [PAGE_W-1:0] cmd_page_o, ue_page_o;
  logic [DATA_W-1:0] rd_data_i, wr0_en_o, wr1_en_o, ecc_raw_o, ecc_data_i;
  logic              ecc_req_o, ecc_ack_i, ecc_fixed_i, ecc_fatal_i, ue_o, busy_o;

  always #4 clk = ~clk;

  scrub_sched #(.PAGES(PAGES), .DATA_W(DATA_W), .INTV_W(INTV_W)) i_scrub_sched (
    .clk(clk), .rst(rst), .interval_i(interval_i), .kick_i(kick_i),
    .bank_req_o(bank_req_o), .bank_gnt_i(bank_gnt_i),
    .io_pend_i(io_pend_i), .io_gnt_o(io_gnt_o), .io_done_i(io_done_i),
    .cmd_rd_o(cmd_rd_o), .cmd_wr_o(cmd_wr_o), .cmd_page_o(cmd_page_o),
    .cmd_done_i(cmd_done_i), .rd_data_i(rd_data_i),
    .wr0_en_o(wr0_en_o), .wr1_en_o(wr1_en_o),
    .ecc_req_o(ecc_req_o), .ecc_raw_o(ecc_raw_o), .ecc_ack_i(ecc_ack_i),
    .ecc_fixed_i(ecc_fixed_i), .ecc_fatal_i(ecc_fatal_i), .ecc_data_i(ecc_data_i),
    .ue_o(ue_o), .ue_page_o(ue_page_o), .busy_o(busy_o)
  );

  int n_chk = 0, n_bad = 0, cycles = 0, passes = 0;
  bit done = 1'b0, live = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Reference model: modes 0 idle,1 wait bank,2 read,3 check,4 write,5 decide,6 host lent
  int m_mode, m_page, m_cnt, m_raw, m_fix, m_uepg;
  bit m_ue;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_page = 0; m_cnt = 0; m_raw = 0; m_fix = 0; m_ue = 0; m_uepg = 0;
      live = 1'b1;
    end else begin
      m_ue = 0;
      case (m_mode)
        0: if (kick_i || m_cnt == int'(interval_i)) begin m_mode = 1; m_cnt = 0; end
           else m_cnt = (m_cnt + 1) % (1 << INTV_W);
        1: if (bank_gnt_i) m_mode = 2;
        2: if (cmd_done_i) begin m_raw = int'(rd_data_i); m_mode = 3; end
        3: if (ecc_ack_i) begin
             if (ecc_fatal_i) begin m_ue = 1; m_uepg = m_page; m_mode = 5; end
             else if (ecc_fixed_i) begin m_fix = int'(ecc_data_i); m_mode = 4; end
             else m_mode = 5;
           end
        4: if (cmd_done_i) m_mode = 5;
        5: if (m_page == PAGES - 1) begin m_page = 0; m_mode = 0; passes++; end
           else begin m_page++; m_mode = io_pend_i ? 6 : 2; end
        6: if (io_done_i) m_mode = 1;
        default: m_mode = 0;
      endcase
    end
  end

  // Responders and per-cycle comparison
  int req_age = 0, cmd_age = 0, io_age = 0;
  bit [PAGES-1:0] pend_mask [3] = '{6'b000110, 6'b000000, 6'b111111};

  always @(negedge clk) begin
    if (live && !rst) begin
      check("R1/R2", "busy_o", int'(busy_o), int'(m_mode != 0));
      check("R3/R7/R8/R9", "bank_req_o", int'(bank_req_o), int'(m_mode >= 1 && m_mode <= 5));
      check("R7/R10", "io_gnt_o", int'(io_gnt_o), int'(m_mode == 6));
      check("R3/R4", "cmd_rd_o", int'(cmd_rd_o), int'(m_mode == 2));
      check("R4", "cmd_wr_o", int'(cmd_wr_o), int'(m_mode == 4));
      check("R4", "ecc_req_o", int'(ecc_req_o), int'(m_mode == 3));
      if (m_mode == 3) check("R4", "ecc_raw_o", int'(ecc_raw_o), m_raw);
      check("R8/R9", "cmd_page_o", int'(cmd_page_o), m_page);
      check("R5", "wr1_en_o", int'(wr1_en_o), (m_mode == 4) ? m_fix : 0);
      check("R5", "wr0_en_o", int'(wr0_en_o), (m_mode == 4) ? (~m_fix & ((1 << DATA_W) - 1)) : 0);
      check("R6", "ue_o", int'(ue_o), int'(m_ue));
      if (m_ue) check("R6", "ue_page_o", int'(ue_page_o), m_uepg);
    end
    req_age = bank_req_o ? req_age + 1 : 0;
    cmd_age = (cmd_rd_o || cmd_wr_o) ? cmd_age + 1 : 0;
    io_age  = io_gnt_o ? io_age + 1 : 0;
    bank_gnt_i  = bank_req_o && (req_age > (passes % 3));
    cmd_done_i  = (cmd_rd_o || cmd_wr_o) && (cmd_age >= 2);
    rd_data_i   = DATA_W'(16'hA500 + 37 * int'(cmd_page_o) + passes);
    ecc_ack_i   = ecc_req_o;
    ecc_fatal_i = ecc_req_o && (cmd_page_o == 3);
    ecc_fixed_i = ecc_req_o && (cmd_page_o != 3) && (((int'(cmd_page_o) + passes) % 2) == 1);
    ecc_data_i  = ecc_raw_o ^ DATA_W'(16'h0104);
    io_done_i   = io_gnt_o && (io_age >= 2);
    io_pend_i   = busy_o && pend_mask[passes % 3][cmd_page_o];
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; kick_i = 1'b0; interval_i = 8'd20;
    bank_gnt_i = 0; io_pend_i = 0; io_done_i = 0; cmd_done_i = 0; rd_data_i = '0;
    ecc_ack_i = 0; ecc_fixed_i = 0; ecc_fatal_i = 0; ecc_data_i = '0;
    repeat (4) @(negedge clk);
    // R1: reset state observed at the ports
    check("R1", "busy_o@reset", int'(busy_o), 0);
    check("R1", "bank_req_o@reset", int'(bank_req_o), 0);
    check("R1", "cmd_page_o@reset", int'(cmd_page_o), 0);
    check("R1", "ue_o@reset", int'(ue_o), 0);
    rst = 1'b0;
    // R2: pass 0 starts from the interval counter; a kick mid-pass is ignored
    while (!(m_mode != 0 && m_page == 2)) @(negedge clk);
    kick_i = 1'b1; @(negedge clk); kick_i = 1'b0;
    check("R2", "busy_o after mid-pass kick", int'(busy_o), 1);
    interval_i = 8'd200;
    while (passes < 1) @(negedge clk);
    check("R9", "page wrap", int'(cmd_page_o), 0);
    repeat (3) @(negedge clk);
    check("R2", "idle before kick", int'(busy_o), 0);
    kick_i = 1'b1; @(negedge clk); kick_i = 1'b0;
    check("R2", "kick starts pass", int'(busy_o), 1);
    while (!(passes == 1 && m_page == 4)) @(negedge clk);
    interval_i = 8'd0;
    while (passes < 3) @(negedge clk);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule